// File: doc/BRIEF.md
# Byte-lane DRAM behavioural array

This block is a clocked, synthesizable stand-in for an asynchronous 16-bit DRAM with two byte lanes. A memory controller or refresh engine under test can drive it. On every clock it samples the active-low row strobe, the two per-lane column strobes, write enable, output enable and the multiplexed address. The order in which those strobes change tells it what kind of cycle is under way, and it then carries that cycle out on a small internal array. Each clock period stands for one unit of strobe timing. Analog timing is not modelled.

A row is opened when the row strobe falls while both column strobes are high. If a column strobe is already low when the row strobe falls, the cycle is a refresh that takes its row from an internal counter. Once a row is open, the first column strobe to fall starts an access. Write enable then selects the access type: low at that moment means an early write, and a later fall means a read-modify-write. A new column can be started without closing the row (page mode). Two checkers run alongside the array. One watches how long the row strobe stays low. The other watches how long each row has gone without being refreshed.

Top module: `dram_lane_model`

## Requirements
- R1: While reset is high and on the first edge after it, `dout`, `dout_en`, `ras_overrun` and `retention_miss` are zero, `cbr_row` is zero and every array word reads zero.
- R2: A falling row strobe with both column strobes high latches the low ROW_AW address bits as the open row. The first column strobe to fall from the both-high state latches the low COL_AW address bits as the column. The array word index is {row, column}.
- R3: A column started with `we_n` high is a read. Starting at the edge that samples it, each lane whose column strobe is low drives the stored byte if `oe_n` is sampled low. `dout_en[0]`/`dout[7:0]` is the lane of `cas_n[0]`, `dout_en[1]`/`dout[15:8]` is the lane of `cas_n[1]`, and disabled lanes read zero.
- R4: A column started with `we_n` low is an early write. It stores `din` at that edge, and `dout_en` stays zero for the whole column cycle.
- R5: Only lanes whose column strobe is sampled low are written. With both low, all 16 bits are written.
- R6: In an open read column, a falling `we_n` writes `din` into the low lanes. Until the column closes, `dout` keeps the data that was read.
- R7: An `oe_n` sampled high clears every `dout_en` bit as of that edge, which means one clock.
- R8: A column strobe low at the edge where the row strobe falls starts a CAS-before-RAS refresh. It refreshes row `cbr_row` (low ROW_AW bits) and advances the 9-bit `cbr_row` by one, wrapping at 512. It performs no array access and drives no output.
- R9: With the row strobe held low, both column strobes going high and then one falling again starts a new column on the same row (page mode). The column closes only when both strobes are high.
- R10: Any row opening, including a RAS-only cycle with no column, refreshes that row. `retention_miss` pulses for one clock when any row goes RETAIN edges without a refresh.
- R11: `ras_overrun` pulses for one clock on the edge that samples the row strobe low for the (RAS_MAX+1)th consecutive time, and only once per low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 2 | Column strobes, bit 0 lower lane, bit 1 upper lane, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, zero on disabled lanes |
| dout_en | output | 2 | Per-lane output drive enable |
| ras_overrun | output | 1 | One-clock pulse when row-active time exceeds RAS_MAX |
| retention_miss | output | 1 | One-clock pulse when a row exceeds the refresh period |
| cbr_row | output | 9 | Internal refresh row counter |

## Verification
The bench goes after the strobe-ordering corners where a mistake turns one cycle type into another. It checks column-low-before-row-fall, where a design that missed it would open a normal row and write the array. It checks write enable low at the column fall, where a wrong decode would drive read data during an early write. It checks write enable falling late, where a wrong design would either overwrite the data on the output or skip the write. It also checks single-lane writes that must leave the other byte intact, page-mode column restarts that a design could fail to see without a new row fall, and output enable deassertion that must cut the drive within a clock. On the timer side, it looks for a row-active overrun that must pulse exactly once rather than every cycle. It also refreshes every row and confirms that no miss appears before the period ends and that each row then misses separately.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;

    localparam int LANES    = 2;
    localparam int LANE_W   = 8;
    localparam int DATA_W   = LANES * LANE_W;
    localparam int REF_CW   = 9;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_CBR  = 2'd2
    } row_phase_e;

    typedef struct packed {
        logic open;
        logic early;
    } col_ctx_t;

    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] m);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i*LANE_W +: LANE_W] = {LANE_W{m[i]}};
        return r;
    endfunction

endpackage

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dram_model_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int ROW_AW = 3,
    parameter int COL_AW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_AW-1:0] row_q,
    output logic              act_pulse,
    output logic              cbr_pulse,
    output logic              rd_pulse,
    output logic              wr_en,
    output logic [COL_AW-1:0] wr_col,
    output logic [LANES-1:0]  wr_lanes,
    output col_ctx_t          ctx_q,
    output col_ctx_t          ctx_next
);

    logic             ras_q, we_q;
    logic [LANES-1:0] cas_q;
    row_phase_e       phase, phase_d;
    logic [COL_AW-1:0] col_q;
    logic             ras_fall, cas_any, cas_was_idle, col_start, rmw;

    assign ras_fall     = ras_q & ~ras_n;
    assign cas_any      = ~&cas_n;
    assign cas_was_idle = &cas_q;

    always_comb begin
        phase_d   = phase;
        act_pulse = 1'b0;
        cbr_pulse = 1'b0;
        case (phase)
            PH_IDLE: if (ras_fall) begin
                if (cas_any) begin
                    phase_d   = PH_CBR;
                    cbr_pulse = 1'b1;
                end else begin
                    phase_d   = PH_ROW;
                    act_pulse = 1'b1;
                end
            end
            default: if (ras_n) phase_d = PH_IDLE;
        endcase
    end

    assign col_start = (phase == PH_ROW) & ~ras_n & cas_was_idle & cas_any;
    assign rmw       = ctx_q.open & ~ctx_q.early & ~col_start & ~ras_n
                     & cas_any & we_q & ~we_n;

    always_comb begin
        ctx_next = ctx_q;
        if (col_start) begin
            ctx_next.open  = 1'b1;
            ctx_next.early = ~we_n;
        end else if (ras_n || !cas_any) begin
            ctx_next.open  = 1'b0;
        end
    end

    assign wr_en    = (col_start & ~we_n) | rmw;
    assign wr_lanes = ~cas_n;
    assign wr_col   = col_start ? addr[COL_AW-1:0] : col_q;
    assign rd_pulse = col_start & we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= '1;
            we_q  <= 1'b1;
            phase <= PH_IDLE;
            ctx_q <= '0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
            phase <= phase_d;
            ctx_q <= ctx_next;
            if (act_pulse) row_q <= addr[ROW_AW-1:0];
            if (col_start) col_q <= addr[COL_AW-1:0];
        end
    end

    // R5: a write always targets at least one lane
    a_r5_write_has_lane: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_lanes != '0));

endmodule

// File: rtl/dram_lane_array.sv
module dram_lane_array
    import dram_model_pkg::*;
#(
    parameter int ROW_AW = 3,
    parameter int COL_AW = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          wr_lanes,
    input  logic [ROW_AW+COL_AW-1:0]  wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ROW_AW+COL_AW-1:0]  rd_addr,
    output logic [DATA_W-1:0]         rd_data
);

    localparam int IDX_W = ROW_AW + COL_AW;
    localparam int DEPTH = 1 << IDX_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            end else if (wr_en && wr_lanes[g]) begin
                bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/dram_refresh_watch.sv
module dram_refresh_watch
    import dram_model_pkg::*;
#(
    parameter int ROW_AW  = 3,
    parameter int RAS_MAX = 200,
    parameter int RETAIN  = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              act_pulse,
    input  logic [ROW_AW-1:0] act_row,
    input  logic              cbr_pulse,
    output logic [REF_CW-1:0] cbr_row,
    output logic              ras_overrun,
    output logic              retention_miss
);

    localparam int ROWS  = 1 << ROW_AW;
    localparam int RC_W  = $clog2(RAS_MAX + 2);
    localparam int AGE_W = $clog2(RETAIN + 1);
    localparam logic [RC_W-1:0]  RC_LIM  = RC_W'(RAS_MAX);
    localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(RETAIN);

    logic [RC_W-1:0]   ras_cnt;
    logic              ref_valid;
    logic [ROW_AW-1:0] ref_row;
    logic [ROWS-1:0]   hit;

    assign ref_valid = act_pulse | cbr_pulse;
    assign ref_row   = act_pulse ? act_row : cbr_row[ROW_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_cnt     <= '0;
            ras_overrun <= 1'b0;
            cbr_row     <= '0;
        end else begin
            ras_overrun <= ~ras_n && (ras_cnt == RC_LIM);
            if (ras_n)                   ras_cnt <= '0;
            else if (ras_cnt <= RC_LIM)  ras_cnt <= ras_cnt + 1'b1;
            if (cbr_pulse)               cbr_row <= cbr_row + 1'b1;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_age
        logic [AGE_W-1:0] age;
        logic             touched;
        assign touched = ref_valid && (ref_row == ROW_AW'(r));
        assign hit[r]  = !touched && (age == AGE_LIM - 1'b1);

        always_ff @(posedge clk) begin
            if (rst)                 age <= '0;
            else if (touched)        age <= '0;
            else if (age != AGE_LIM) age <= age + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) retention_miss <= 1'b0;
        else     retention_miss <= |hit;
    end

    // R11: the overrun flag is a single-clock pulse
    a_r11_one_pulse: assert property (@(posedge clk) disable iff (rst)
        ras_overrun |=> !ras_overrun);

    // R8: each refresh-by-counter advances the counter by one
    a_r8_cbr_step: assert property (@(posedge clk) disable iff (rst)
        cbr_pulse |=> (cbr_row == $past(cbr_row) + 1'b1));

endmodule

// File: rtl/dram_lane_model.sv
module dram_lane_model
    import dram_model_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int ROW_AW  = 3,
    parameter int COL_AW  = 2,
    parameter int RAS_MAX = 200,
    parameter int RETAIN  = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic [1:0]        cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        dout_en,
    output logic              ras_overrun,
    output logic              retention_miss,
    output logic [8:0]        cbr_row
);

    localparam int IDX_W = ROW_AW + COL_AW;

    logic [ROW_AW-1:0] row_q;
    logic              act_pulse, cbr_pulse, rd_pulse, wr_en;
    logic [COL_AW-1:0] wr_col;
    logic [LANES-1:0]  wr_lanes;
    col_ctx_t          ctx_q, ctx_next;
    logic [DATA_W-1:0] rd_word, rd_hold;
    logic [LANES-1:0]  lane_en_q;

    dram_strobe_decoder #(.ADDR_W(ADDR_W), .ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_dec (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .row_q(row_q), .act_pulse(act_pulse), .cbr_pulse(cbr_pulse), .rd_pulse(rd_pulse),
        .wr_en(wr_en), .wr_col(wr_col), .wr_lanes(wr_lanes),
        .ctx_q(ctx_q), .ctx_next(ctx_next)
    );

    dram_lane_array #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_arr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lanes(wr_lanes),
        .wr_addr({row_q, wr_col}), .wr_data(din),
        .rd_addr({row_q, addr[COL_AW-1:0]}), .rd_data(rd_word)
    );

    dram_refresh_watch #(.ROW_AW(ROW_AW), .RAS_MAX(RAS_MAX), .RETAIN(RETAIN)) u_watch (
        .clk(clk), .rst(rst), .ras_n(ras_n), .act_pulse(act_pulse),
        .act_row(addr[ROW_AW-1:0]), .cbr_pulse(cbr_pulse), .cbr_row(cbr_row),
        .ras_overrun(ras_overrun), .retention_miss(retention_miss)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hold   <= '0;
            lane_en_q <= '0;
        end else begin
            if (rd_pulse) rd_hold <= rd_word;
            lane_en_q <= {LANES{ctx_next.open & ~ctx_next.early & ~oe_n}} & ~cas_n;
        end
    end

    assign dout    = rd_hold & lane_bits(lane_en_q);
    assign dout_en = lane_en_q;

    // R7: output enable high turns every lane off by the next clock
    a_r7_oe_off: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> (dout_en == '0));

    // R3: a lane only drives inside an open column
    a_r3_lane_gate: assert property (@(posedge clk) disable iff (rst)
        (|dout_en) |-> ctx_q.open);

endmodule

// File: tb/dram_lane_model_bench.sv
module dram_lane_model_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RAS_MAX    = 24;
    localparam int RETAIN     = 600;
    localparam int NROWS      = 8;
    localparam int NCOLS      = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ras_n = 1'b1;
    logic [1:0]  cas_n = 2'b11;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0]  dout_en;
    logic        ras_overrun, retention_miss;
    logic [8:0]  cbr_row;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_lane_model #(.ADDR_W(9), .ROW_AW(3), .COL_AW(2),
                      .RAS_MAX(RAS_MAX), .RETAIN(RETAIN)) u_dram_lane_model (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .ras_overrun(ras_overrun), .retention_miss(retention_miss), .cbr_row(cbr_row)
    );

    // ---------------- reference model ----------------
    int        m_phase, m_row, m_col, m_cnt, m_rc;
    bit        m_ras_q, m_we_q, m_open, m_early, m_ovr, m_miss;
    bit [1:0]  m_cas_q, m_en;
    bit [15:0] m_hold;
    bit [15:0] mem [NROWS*NCOLS];
    int        m_age [NROWS];

    task automatic mem_write(int idx, bit [1:0] lanes, bit [15:0] d);
        if (lanes[0]) mem[idx][7:0]  = d[7:0];
        if (lanes[1]) mem[idx][15:8] = d[15:8];
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_row = 0; m_col = 0; m_cnt = 0; m_rc = 0;
            m_ras_q = 1; m_we_q = 1; m_cas_q = 2'b11; m_open = 0; m_early = 0;
            m_ovr = 0; m_miss = 0; m_en = 0; m_hold = 0;
            foreach (mem[i]) mem[i] = 0;
            foreach (m_age[i]) m_age[i] = 0;
        end else begin
            bit fall, any, idle, act, cbr, cs, rmw, n_open, n_early;
            int nphase, ref_r;
            fall = m_ras_q && !ras_n;
            any  = (cas_n != 2'b11);
            idle = (m_cas_q == 2'b11);
            act = 0; cbr = 0; nphase = m_phase;
            if (m_phase == 0) begin
                if (fall) begin
                    if (any) begin nphase = 2; cbr = 1; end
                    else     begin nphase = 1; act = 1; end
                end
            end else if (ras_n) nphase = 0;
            cs  = (m_phase == 1) && !ras_n && idle && any;
            rmw = m_open && !m_early && !cs && !ras_n && any && m_we_q && !we_n;
            if (cs && we_n)  m_hold = mem[m_row*NCOLS + int'(addr[1:0])];
            if (cs && !we_n) mem_write(m_row*NCOLS + int'(addr[1:0]), ~cas_n, din);
            if (rmw)         mem_write(m_row*NCOLS + m_col, ~cas_n, din);
            n_open = m_open; n_early = m_early;
            if (cs) begin n_open = 1; n_early = !we_n; end
            else if (ras_n || !any) n_open = 0;
            m_en = (n_open && !n_early && !oe_n) ? ~cas_n : 2'b00;
            // row-active timer
            m_ovr = 0;
            if (ras_n) m_rc = 0;
            else begin
                m_ovr = (m_rc == RAS_MAX);
                if (m_rc <= RAS_MAX) m_rc++;
            end
            // retention
            ref_r = act ? int'(addr[2:0]) : (m_cnt % NROWS);
            m_miss = 0;
            for (int r = 0; r < NROWS; r++) begin
                if ((act || cbr) && ref_r == r) m_age[r] = 0;
                else if (m_age[r] < RETAIN) begin
                    m_age[r]++;
                    if (m_age[r] == RETAIN) m_miss = 1;
                end
            end
            if (cbr) m_cnt = (m_cnt + 1) % 512;
            if (act) m_row = int'(addr[2:0]);
            if (cs)  m_col = int'(addr[1:0]);
            m_phase = nphase; m_open = n_open; m_early = n_early;
            m_ras_q = ras_n; m_cas_q = cas_n; m_we_q = we_n;
        end
    end

    function automatic bit [15:0] model_dout();
        return {m_en[1] ? m_hold[15:8] : 8'h00, m_en[0] ? m_hold[7:0] : 8'h00};
    endfunction

    task automatic check(bit ok, string tag, int act_v, int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic compare_model();
        check(dout == model_dout(), "R3 model dout", int'(dout), int'(model_dout()));
        check(dout_en == m_en, "R3 model dout_en", int'(dout_en), int'(m_en));
        check(ras_overrun == m_ovr, "R11 model ras_overrun", int'(ras_overrun), int'(m_ovr));
        check(retention_miss == m_miss, "R10 model retention_miss", int'(retention_miss), int'(m_miss));
        check(cbr_row == 9'(m_cnt), "R8 model cbr_row", int'(cbr_row), m_cnt);
    endtask

    int miss_seen = 0;
    int ovr_seen  = 0;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (retention_miss) miss_seen++;
        if (ras_overrun)    ovr_seen++;
        if (!rst) compare_model();
    endtask

    task automatic idle(int n);
        ras_n = 1; cas_n = 2'b11; we_n = 1; oe_n = 1;
        repeat (n) tick();
    endtask

    task automatic open_row(int row);
        ras_n = 1; cas_n = 2'b11; we_n = 1; addr = 9'(row); tick();
        ras_n = 0; tick();
    endtask

    task automatic close_row();
        cas_n = 2'b11; we_n = 1; oe_n = 1; tick();
        ras_n = 1; tick();
    endtask

    task automatic write_word(int row, int col, bit [1:0] lanes, bit [15:0] d);
        open_row(row);
        addr = 9'(col); din = d; we_n = 0; oe_n = 0; cas_n = ~lanes; tick();
        check(dout_en == 2'b00, "R4 early write keeps outputs off", int'(dout_en), 0);
        we_n = 1; tick();
        check(dout_en == 2'b00, "R4 early write off through cycle", int'(dout_en), 0);
        close_row();
    endtask

    task automatic read_word(int row, int col, bit [1:0] lanes, output bit [15:0] q, output bit [1:0] en);
        open_row(row);
        addr = 9'(col); we_n = 1; oe_n = 0; cas_n = ~lanes; tick();
        q = dout; en = dout_en;
        close_row();
    endtask

    initial begin
        bit [15:0] q;
        bit [1:0]  en;
        int c0;
        repeat (3) @(negedge clk);
        check(dout == 0 && dout_en == 0 && !ras_overrun && !retention_miss && cbr_row == 0,
              "R1 outputs in reset", int'(dout), 0);
        rst = 0;
        tick();
        check(dout_en == 0 && cbr_row == 0, "R1 first edge after reset", int'(cbr_row), 0);
        read_word(5, 3, 2'b11, q, en);
        check(q == 16'h0000, "R1 array cleared", int'(q), 0);

        // R2 R3 R4: full word write, read back both lanes
        write_word(2, 1, 2'b11, 16'hA55A);
        read_word(2, 1, 2'b11, q, en);
        check(q == 16'hA55A, "R2 read back word", int'(q), 'hA55A);
        check(en == 2'b11, "R3 both lanes enabled", int'(en), 3);
        read_word(2, 1, 2'b01, q, en);
        check(q == 16'h005A && en == 2'b01, "R3 lower lane only", int'(q), 'h005A);
        // row/column aliasing on the low address bits
        read_word(10, 5, 2'b11, q, en);
        check(q == 16'hA55A, "R2 low address bits index array", int'(q), 'hA55A);

        // R5: upper-lane write leaves lower byte
        write_word(2, 1, 2'b10, 16'h3C77);
        read_word(2, 1, 2'b11, q, en);
        check(q == 16'h3C5A, "R5 byte-selective write", int'(q), 'h3C5A);

        // R6: read-modify-write
        open_row(2);
        addr = 9'd1; we_n = 1; oe_n = 0; cas_n = 2'b00; tick();
        check(dout == 16'h3C5A, "R6 rmw read phase", int'(dout), 'h3C5A);
        din = 16'h1234; we_n = 0; tick();
        check(dout == 16'h3C5A, "R6 output holds read data", int'(dout), 'h3C5A);
        tick();
        // R7: oe high cuts the drive in one clock
        oe_n = 1; tick();
        check(dout_en == 2'b00, "R7 oe high disables lanes", int'(dout_en), 0);
        close_row();
        read_word(2, 1, 2'b11, q, en);
        check(q == 16'h1234, "R6 rmw data written", int'(q), 'h1234);

        // R9: page mode across two columns
        write_word(2, 2, 2'b11, 16'hBEEF);
        open_row(2);
        addr = 9'd1; oe_n = 0; cas_n = 2'b00; tick();
        check(dout == 16'h1234, "R9 page column one", int'(dout), 'h1234);
        cas_n = 2'b01; tick();
        cas_n = 2'b11; tick();
        addr = 9'd2; cas_n = 2'b00; tick();
        check(dout == 16'hBEEF, "R9 page column two", int'(dout), 'hBEEF);
        close_row();

        // R8: CAS-before-RAS refresh
        c0 = int'(cbr_row);
        for (int k = 0; k < 3; k++) begin
            addr = 9'd2; din = 16'hFFFF; we_n = 0; cas_n = 2'b00; tick();
            ras_n = 0; oe_n = 0; tick();
            check(dout_en == 2'b00, "R8 no output during refresh", int'(dout_en), 0);
            tick();
            ras_n = 1; cas_n = 2'b11; we_n = 1; oe_n = 1; tick();
        end
        check(int'(cbr_row) == c0 + 3, "R8 counter advanced", int'(cbr_row), c0 + 3);
        read_word(2, 2, 2'b11, q, en);
        check(q == 16'hBEEF, "R8 refresh leaves array", int'(q), 'hBEEF);

        // R11: row strobe held too long
        ovr_seen = 0;
        addr = 9'd4; ras_n = 0; cas_n = 2'b11;
        repeat (RAS_MAX + 6) tick();
        ras_n = 1; tick();
        check(ovr_seen == 1, "R11 single overrun pulse", ovr_seen, 1);
        ovr_seen = 0;
        ras_n = 0; repeat (RAS_MAX - 2) tick();
        ras_n = 1; tick();
        check(ovr_seen == 0, "R11 no pulse within limit", ovr_seen, 0);

        // R10: RAS-only refresh of every row, then retention window
        for (int r = 0; r < NROWS; r++) begin
            addr = 9'(r); ras_n = 1; tick();
            ras_n = 0; tick();
            ras_n = 1; tick();
        end
        miss_seen = 0;
        idle(RETAIN - 30);
        check(miss_seen == 0, "R10 no miss inside period", miss_seen, 0);
        idle(60);
        check(miss_seen == NROWS, "R10 each row misses once", miss_seen, NROWS);
        idle(5);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule